// File: doc/BRIEF.md
# Pipelined Floating-Point Adder

This block adds two floating-point numbers whose exponent width and fraction width are set by parameters. Each word is laid out as a sign bit at the top, then a biased exponent, then a fraction that has an implied leading one above it. The bias is 2^(EXP_W-1)-1. The pipeline is fully registered with four stages. Stage one sorts the operands by magnitude. Stage two shifts the smaller significand right to line it up with the larger one. Stage three adds or subtracts the two significands. Stage four normalises the result and packs it.

A start strobe travels down the pipeline beside the operands. It comes out as an end strobe in the same cycle as the matching sum, so a one-hot statement controller can simply wait on that strobe. The adder takes a new operand pair on every clock. It exerts no back-pressure: there is no ready signal, and a consumer that is not prepared for a result on the cycle the end strobe is high loses that result. The unit does not model NaN, infinity, subnormals or exception flags, and it rounds by truncation only.

Top module: `fpadd_pipe`

## Requirements
- R1: Bit layout. Each word is {sign, exponent[EXP_W-1:0], fraction[FRAC_W-1:0]}, with the sign in the most significant bit. A word whose exponent is nonzero has the value (-1)^sign × 1.fraction × 2^(exponent − (2^(EXP_W-1)−1)). Defaults are EXP_W=8 and FRAC_W=23, and other widths such as 5/10 behave the same way.
- R2: Latency. If start is high on the clock edge that captures an operand pair, then done is high, and sum carries that pair's result, for exactly one cycle starting 4 rising edges later. Otherwise done is low.
- R3: Throughput. A new pair may be presented on every edge, including back-to-back runs. The result of each pair is independent of the pairs around it.
- R4: Zero operands. An operand whose exponent field is 0 counts as zero, whatever its fraction holds. If both operands are zero, the sum is the all-zero word (+0).
- R5: Datapath arithmetic.
  - The larger significand gets 3 zero guard bits appended.
  - The smaller significand is extended the same way, then shifted right by the exponent difference. Bits shifted past the guard bits are discarded.
  - The two are added when the signs match and subtracted otherwise.
  - The result is normalised so the leading one lands at the hidden-bit position, and any bits below the fraction are truncated.
- R6: Exact cancellation. If the two operands have equal magnitude and opposite signs, the sum is +0, the all-zero word.
- R7: Underflow. If the normalised exponent would be 0 or below, the result is flushed to +0.
- R8: Overflow. If the normalised exponent would reach 2^EXP_W−1 or more, the result saturates to the correct sign, exponent 2^EXP_W−2 and an all-ones fraction. The all-ones exponent is never produced. An input with an all-ones exponent is treated as an ordinary value.
- R9: Reset. While rst_n is low, done is low and start is ignored. A start given during reset never produces a done.
- R10: Sign. The result takes the sign of the operand with the larger magnitude, where magnitude is compared as {exponent, fraction}. When the magnitudes are equal, the sign of opa is used, except in the case R6 covers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Marks opa/opb as a valid pair on this edge |
| opa | input | EXP_W+FRAC_W+1 | First operand |
| opb | input | EXP_W+FRAC_W+1 | Second operand |
| done | output | 1 | Marks sum as valid, four edges after start |
| sum | output | EXP_W+FRAC_W+1 | Result word |

## Verification
The hardest results to reach from the ports are the ones where a subtraction cancels most of the significand: the leading-zero count is large and the exponent drops toward or past the flush threshold. Random operands with unrelated exponents almost never produce this. The stimulus therefore builds pairs with opposite signs, equal or adjacent exponents and fractions that differ in only the low bits. It also places such pairs at exponent 1 and exponent 2, so that R7 triggers. Overflow and all-ones-exponent inputs are built directly at the top of the exponent range. Both width settings run the same schedule at the same time, back to back, so every stage holds a different pair on every cycle.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  // Guard bits kept below the result LSB during alignment.
  localparam int GUARD_W = 3;

  // Outcome class of the normalisation stage.
  typedef enum logic [1:0] {
    RES_ZERO = 2'd0,
    RES_NORM = 2'd1,
    RES_SAT  = 2'd2
  } res_kind_e;
endpackage

// File: rtl/fpadd_sort.sv
// Stage 1: unpack, treat zero exponents as zero, order by magnitude.
module fpadd_sort #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int SIG_W = FRAC_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic [EXP_W+FRAC_W:0]   opa,
  input  logic [EXP_W+FRAC_W:0]   opb,
  output logic                    s1_vld,
  output logic                    s1_sign,
  output logic                    s1_sub,
  output logic [EXP_W-1:0]        s1_exp,
  output logic [EXP_W-1:0]        s1_diff,
  output logic [SIG_W-1:0]        s1_big,
  output logic [SIG_W-1:0]        s1_small
);
  logic [EXP_W-1:0]        exp_a, exp_b;
  logic [FRAC_W-1:0]       frac_a, frac_b;
  logic [SIG_W-1:0]        sig_a, sig_b;
  logic                    a_first;

  always_comb begin
    exp_a  = opa[FRAC_W +: EXP_W];
    exp_b  = opb[FRAC_W +: EXP_W];
    frac_a = (exp_a == '0) ? '0 : opa[FRAC_W-1:0];
    frac_b = (exp_b == '0) ? '0 : opb[FRAC_W-1:0];
    sig_a  = (exp_a == '0) ? '0 : {1'b1, frac_a};
    sig_b  = (exp_b == '0) ? '0 : {1'b1, frac_b};
    a_first = {exp_a, frac_a} >= {exp_b, frac_b};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_vld <= 1'b0;
    else        s1_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    s1_sub <= opa[EXP_W+FRAC_W] ^ opb[EXP_W+FRAC_W];
    if (a_first) begin
      s1_sign  <= opa[EXP_W+FRAC_W];
      s1_exp   <= exp_a;
      s1_diff  <= exp_a - exp_b;
      s1_big   <= sig_a;
      s1_small <= sig_b;
    end else begin
      s1_sign  <= opb[EXP_W+FRAC_W];
      s1_exp   <= exp_b;
      s1_diff  <= exp_b - exp_a;
      s1_big   <= sig_b;
      s1_small <= sig_a;
    end
  end
endmodule

// File: rtl/fpadd_align.sv
// Stage 2: append guard bits and shift the smaller significand right.
module fpadd_align
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int SIG_W = FRAC_W + 1,
  localparam int EXT_W = SIG_W + GUARD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s1_vld,
  input  logic               s1_sign,
  input  logic               s1_sub,
  input  logic [EXP_W-1:0]   s1_exp,
  input  logic [EXP_W-1:0]   s1_diff,
  input  logic [SIG_W-1:0]   s1_big,
  input  logic [SIG_W-1:0]   s1_small,
  output logic               s2_vld,
  output logic               s2_sign,
  output logic               s2_sub,
  output logic [EXP_W-1:0]   s2_exp,
  output logic [EXT_W-1:0]   s2_big,
  output logic [EXT_W-1:0]   s2_small
);
  logic [EXT_W-1:0] small_ext, small_shr;

  always_comb begin
    small_ext = {s1_small, {GUARD_W{1'b0}}};
    small_shr = small_ext >> s1_diff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_vld <= 1'b0;
    else        s2_vld <= s1_vld;
  end

  always_ff @(posedge clk) begin
    s2_sign  <= s1_sign;
    s2_sub   <= s1_sub;
    s2_exp   <= s1_exp;
    s2_big   <= {s1_big, {GUARD_W{1'b0}}};
    s2_small <= small_shr;
  end
endmodule

// File: rtl/fpadd_addsub.sv
// Stage 3: add or subtract the aligned significands (big >= small).
module fpadd_addsub
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int EXT_W = FRAC_W + 1 + GUARD_W,
  localparam int SUM_W = EXT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s2_vld,
  input  logic               s2_sign,
  input  logic               s2_sub,
  input  logic [EXP_W-1:0]   s2_exp,
  input  logic [EXT_W-1:0]   s2_big,
  input  logic [EXT_W-1:0]   s2_small,
  output logic               s3_vld,
  output logic               s3_sign,
  output logic [EXP_W-1:0]   s3_exp,
  output logic [SUM_W-1:0]   s3_sum
);
  logic [SUM_W-1:0] raw;

  always_comb begin
    if (s2_sub) raw = {1'b0, s2_big} - {1'b0, s2_small};
    else        raw = {1'b0, s2_big} + {1'b0, s2_small};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s3_vld <= 1'b0;
    else        s3_vld <= s2_vld;
  end

  always_ff @(posedge clk) begin
    s3_sign <= s2_sign;
    s3_exp  <= s2_exp;
    s3_sum  <= raw;
  end
endmodule

// File: rtl/fpadd_normalize.sv
// Stage 4: leading-zero count, exponent adjust, flush / saturate, pack.
module fpadd_normalize
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int SUM_W = FRAC_W + 2 + GUARD_W,
  localparam int LZ_W  = $clog2(SUM_W + 1),
  localparam int EW2   = ((EXP_W > LZ_W) ? EXP_W : LZ_W) + 2,
  localparam int MAX_E = (1 << EXP_W) - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s3_vld,
  input  logic                  s3_sign,
  input  logic [EXP_W-1:0]      s3_exp,
  input  logic [SUM_W-1:0]      s3_sum,
  output logic                  done,
  output logic [EXP_W+FRAC_W:0] sum
);
  localparam logic signed [EW2-1:0] E_ONE  = EW2'(1);
  localparam logic signed [EW2-1:0] E_ZERO = '0;
  localparam logic signed [EW2-1:0] E_MAX  = EW2'(MAX_E);

  logic [LZ_W-1:0]         lz;
  logic                    seen;
  logic signed [EW2-1:0]   e_new;
  logic [SUM_W-1:0]        norm;
  logic [FRAC_W-1:0]       frac_n;
  res_kind_e               kind;
  logic [EXP_W+FRAC_W:0]   packed_w;

  always_comb begin
    lz   = '0;
    seen = 1'b0;
    for (int i = SUM_W - 1; i >= 0; i--) begin
      if (!seen) begin
        if (s3_sum[i]) seen = 1'b1;
        else           lz   = lz + LZ_W'(1);
      end
    end
  end

  always_comb begin
    e_new  = $signed({{(EW2-EXP_W){1'b0}}, s3_exp}) + E_ONE
           - $signed({{(EW2-LZ_W){1'b0}}, lz});
    norm   = s3_sum << lz;
    frac_n = FRAC_W'(norm >> (SUM_W - 1 - FRAC_W));
    if (s3_sum == '0 || e_new <= E_ZERO) kind = RES_ZERO;
    else if (e_new >= E_MAX)             kind = RES_SAT;
    else                                 kind = RES_NORM;
    unique case (kind)
      RES_ZERO: packed_w = '0;
      RES_SAT:  packed_w = {s3_sign, EXP_W'(MAX_E - 1), {FRAC_W{1'b1}}};
      default:  packed_w = {s3_sign, EXP_W'(e_new), frac_n};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= s3_vld;
  end

  always_ff @(posedge clk) begin
    sum <= packed_w;
  end
endmodule

// File: rtl/fpadd_pipe.sv
// Four-stage floating-point adder with a start/done strobe in lockstep.
module fpadd_pipe
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [EXP_W+FRAC_W:0] opa,
  input  logic [EXP_W+FRAC_W:0] opb,
  output logic                  done,
  output logic [EXP_W+FRAC_W:0] sum
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int EXT_W = SIG_W + GUARD_W;
  localparam int SUM_W = EXT_W + 1;

  logic               s1_vld, s1_sign, s1_sub;
  logic [EXP_W-1:0]   s1_exp, s1_diff;
  logic [SIG_W-1:0]   s1_big, s1_small;

  logic               s2_vld, s2_sign, s2_sub;
  logic [EXP_W-1:0]   s2_exp;
  logic [EXT_W-1:0]   s2_big, s2_small;

  logic               s3_vld, s3_sign;
  logic [EXP_W-1:0]   s3_exp;
  logic [SUM_W-1:0]   s3_sum;

  fpadd_sort #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sort (
    .clk(clk), .rst_n(rst_n), .in_vld(start), .opa(opa), .opb(opb),
    .s1_vld(s1_vld), .s1_sign(s1_sign), .s1_sub(s1_sub), .s1_exp(s1_exp),
    .s1_diff(s1_diff), .s1_big(s1_big), .s1_small(s1_small)
  );

  fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .clk(clk), .rst_n(rst_n), .s1_vld(s1_vld), .s1_sign(s1_sign),
    .s1_sub(s1_sub), .s1_exp(s1_exp), .s1_diff(s1_diff), .s1_big(s1_big),
    .s1_small(s1_small), .s2_vld(s2_vld), .s2_sign(s2_sign), .s2_sub(s2_sub),
    .s2_exp(s2_exp), .s2_big(s2_big), .s2_small(s2_small)
  );

  fpadd_addsub #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_addsub (
    .clk(clk), .rst_n(rst_n), .s2_vld(s2_vld), .s2_sign(s2_sign),
    .s2_sub(s2_sub), .s2_exp(s2_exp), .s2_big(s2_big), .s2_small(s2_small),
    .s3_vld(s3_vld), .s3_sign(s3_sign), .s3_exp(s3_exp), .s3_sum(s3_sum)
  );

  fpadd_normalize #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .clk(clk), .rst_n(rst_n), .s3_vld(s3_vld), .s3_sign(s3_sign),
    .s3_exp(s3_exp), .s3_sum(s3_sum), .done(done), .sum(sum)
  );
endmodule

// File: rtl/fpadd_pipe_chk.sv
// Port-level properties of the adder, bound to every instance.
module fpadd_pipe_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic [EXP_W+FRAC_W:0] opa,
  input logic [EXP_W+FRAC_W:0] opb,
  input logic                  done,
  input logic [EXP_W+FRAC_W:0] sum
);
  localparam logic [EXP_W+FRAC_W:0] SIGN_BIT = {1'b1, {(EXP_W+FRAC_W){1'b0}}};

  logic [2:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_cnt <= '0;
    else if (warm_cnt != 4) warm_cnt <= warm_cnt + 3'd1;
  end
  assign warm = (warm_cnt == 3'd4);

  AST_END_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (done == $past(start, 4))) else $error("end strobe misaligned"); // R2

  AST_NO_TOP_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sum[FRAC_W +: EXP_W] != '1)) else $error("all-ones exponent produced"); // R8

  AST_ZERO_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sum[FRAC_W +: EXP_W] == '0) |-> (sum == '0)) else $error("non-canonical zero"); // R7

  AST_CANCEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(start && opa == (opb ^ SIGN_BIT), 4)) |-> (sum == '0))
    else $error("equal opposite operands not +0"); // R6

  AST_ZERO_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(start && opa[FRAC_W +: EXP_W] == '0 && opb[FRAC_W +: EXP_W] == '0, 4))
    |-> (sum == '0)) else $error("zero operands not +0"); // R4
endmodule

bind fpadd_pipe fpadd_pipe_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fpadd_pipe_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
  .done(done), .sum(sum)
);

// File: tb/fpadd_pipe_bench.sv
module fpadd_pipe_bench;
  localparam int CLK_NS = 20;
  localparam int SE = 8,  SF = 23;
  localparam int HE = 5,  HF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [15:0] hopa = '0, hopb = '0;
  logic done_s, done_h;
  logic [31:0] sum_s;
  logic [15:0] sum_h;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  fpadd_pipe #(.EXP_W(SE), .FRAC_W(SF)) u_fpadd_pipe (
    .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
    .done(done_s), .sum(sum_s));

  fpadd_pipe #(.EXP_W(HE), .FRAC_W(HF)) u_fpadd_pipe_h (
    .clk(clk), .rst_n(rst_n), .start(start), .opa(hopa), .opb(hopb),
    .done(done_h), .sum(sum_h));

  // Behavioural model of the R1/R4-R8/R10 arithmetic.
  function automatic longint ref_add(longint a, longint b, int E, int F);
    longint fm = (longint'(1) << F) - 1;
    longint em = (longint'(1) << E) - 1;
    longint sa = (a >> (E+F)) & 1, sb = (b >> (E+F)) & 1;
    longint ea = (a >> F) & em, eb = (b >> F) & em;
    longint fa = (ea == 0) ? 0 : (a & fm);
    longint fb = (eb == 0) ? 0 : (b & fm);
    longint ma = (ea == 0) ? 0 : ((longint'(1) << F) | fa);
    longint mb = (eb == 0) ? 0 : ((longint'(1) << F) | fb);
    longint bs, be, bm, sm, d, al, tot, en, fr;
    int p;
    if (((ea << F) | fa) >= ((eb << F) | fb)) begin
      bs = sa; be = ea; bm = mb; bm = ma; sm = mb; d = ea - eb;
    end else begin
      bs = sb; be = eb; bm = mb; sm = ma; d = eb - ea;
    end
    al = (d > 60) ? 0 : ((sm << 3) >> d);
    tot = (sa != sb) ? ((bm << 3) - al) : ((bm << 3) + al);
    if (tot == 0) return 0;
    p = 0;
    for (int i = 62; i >= 0; i--) if (((tot >> i) & 1) == 1) begin p = i; break; end
    en = be + p - (F + 3);
    if (en <= 0) return 0;
    if (en >= em) return (bs << (E+F)) | ((em - 1) << F) | fm;
    fr = (p >= F) ? (tot >> (p - F)) : (tot << (F - p));
    return (bs << (E+F)) | (en << F) | (fr & fm);
  endfunction

  // Model pipelines, four entries deep.
  bit          pv[4];
  longint      ps[4], ph[4];
  string       pt[4];

  task automatic fail_line(string tag, string what, longint act, longint exp_v);
    errors++;
    $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp_v);
  endtask

  task automatic step(input bit st, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] ha, input logic [15:0] hb, input string tag);
    start = st; opa = a; opb = b; hopa = ha; hopb = hb;
    @(posedge clk);
    #1;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) pv[i] = 1'b0;
    end else begin
      for (int i = 3; i > 0; i--) begin
        pv[i] = pv[i-1]; ps[i] = ps[i-1]; ph[i] = ph[i-1]; pt[i] = pt[i-1];
      end
      pv[0] = st;
      ps[0] = ref_add(longint'(a), longint'(b), SE, SF);
      ph[0] = ref_add(longint'(ha), longint'(hb), HE, HF);
      pt[0] = tag;
    end
    checks++;
    if (done_s !== pv[3]) fail_line(rst_n ? "R2" : "R9", "done(8/23)", longint'(done_s), longint'(pv[3]));
    checks++;
    if (done_h !== pv[3]) fail_line(rst_n ? "R2" : "R9", "done(5/10)", longint'(done_h), longint'(pv[3]));
    if (pv[3]) begin
      checks++;
      if (longint'(sum_s) !== ps[3]) fail_line(pt[3], "sum(8/23)", longint'(sum_s), ps[3]);
      checks++;
      if (longint'(sum_h) !== ph[3]) fail_line(pt[3], "sum(5/10)", longint'(sum_h), ph[3]);
    end
  endtask

  function automatic logic [31:0] s32(bit s, int e, int f);
    return {s, 8'(e), 23'(f)};
  endfunction
  function automatic logic [15:0] h16(bit s, int e, int f);
    return {s, 5'(e), 10'(f)};
  endfunction

  task automatic flush_pipe();
    for (int i = 0; i < 5; i++) step(1'b0, '0, '0, '0, '0, "idle");
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) pv[i] = 1'b0;
    // R9: start held high during reset must never yield done.
    for (int i = 0; i < 4; i++)
      step(1'b1, s32(0,127,0), s32(0,127,0), h16(0,15,0), h16(0,15,0), "R9");
    rst_n = 1'b1;
    flush_pipe();

    // R1 R5: plain additions.
    step(1, s32(0,127,0), s32(0,127,0), h16(0,15,0), h16(0,15,0), "R1 one+one");
    step(1, s32(0,127,23'h400000), s32(0,125,0), h16(0,15,10'h200), h16(0,13,0), "R5 1.5+0.25");
    // R10: sign follows larger magnitude.
    step(1, s32(0,127,0), s32(1,128,23'h400000), h16(0,15,0), h16(1,16,10'h200), "R10 1-3");
    step(1, s32(1,130,5), s32(0,130,5), h16(1,18,5), h16(0,18,5), "R6 cancel");
    // R4: zero exponents, nonzero fraction ignored; negative zeros.
    step(1, s32(0,0,23'h7fffff), s32(0,127,9), h16(0,0,10'h3ff), h16(0,15,9), "R4 z+x");
    step(1, s32(1,0,0), s32(1,0,0), h16(1,0,0), h16(1,0,0), "R4 -0+-0");
    step(1, s32(0,0,3), s32(1,0,1), h16(0,0,3), h16(1,0,1), "R4 dz");
    // R7: underflow through cancellation at minimum exponent.
    step(1, s32(0,1,23'h400000), s32(1,1,0), h16(0,1,10'h200), h16(1,1,0), "R7 flush");
    step(1, s32(0,2,0), s32(1,1,23'h7fffff), h16(0,2,0), h16(1,1,10'h3ff), "R7 deep");
    // R8: overflow and all-ones exponent inputs.
    step(1, s32(0,254,23'h7fffff), s32(0,254,23'h7fffff), h16(0,30,10'h3ff), h16(0,30,10'h3ff), "R8 sat+");
    step(1, s32(1,255,0), s32(1,254,1), h16(1,31,0), h16(1,30,1), "R8 sat-");
    step(1, s32(0,255,7), s32(1,200,0), h16(0,31,7), h16(1,20,0), "R8 topin");
    // R5: large exponent gap, subtraction with massive cancellation, guard truncation.
    step(1, s32(0,200,11), s32(0,10,22), h16(0,28,11), h16(0,2,22), "R5 gap");
    step(1, s32(0,127,0), s32(1,126,23'h7fffff), h16(0,15,0), h16(1,14,10'h3ff), "R5 ulp");
    step(1, s32(0,127,1), s32(1,100,23'h123456), h16(0,15,1), h16(1,3,10'h1a5), "R5 guard");
    step(1, s32(1,127,0), s32(1,128,1), h16(1,15,0), h16(1,16,1), "R5 carry");
    flush_pipe();

    // R3: back-to-back random stream with gaps, both widths at once.
    for (int n = 0; n < 3000; n++) begin
      bit st = ($urandom_range(0, 7) != 0);
      int mode = $urandom_range(0, 3);
      int e1 = (mode == 0) ? $urandom_range(0, 255) : $urandom_range(115, 140);
      int e2 = (mode == 1) ? e1 + $urandom_range(0, 2) - 1 : (mode == 0) ? $urandom_range(0, 255) : $urandom_range(115, 140);
      int h1 = (mode == 0) ? $urandom_range(0, 31) : $urandom_range(10, 20);
      int h2 = (mode == 1) ? h1 + $urandom_range(0, 2) - 1 : (mode == 0) ? $urandom_range(0, 31) : $urandom_range(10, 20);
      int f1 = $urandom;
      int f2 = (mode == 1) ? (f1 ^ $urandom_range(0, 15)) : $urandom;
      if (e2 < 0) e2 = 0;
      if (h2 < 0) h2 = 0;
      if (mode == 3) begin
        e1 = $urandom_range(1, 3); e2 = $urandom_range(1, 3);
        h1 = $urandom_range(1, 3); h2 = $urandom_range(1, 3);
      end
      step(st, s32(1'($urandom), e1, f1), s32(1'($urandom), e2, f2),
           h16(1'($urandom), h1, f1), h16(1'($urandom), h2, f2), "R3 R5 stream");
    end
    flush_pipe();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule